// File: doc/BRIEF.md
# Serial Time-Frame Access Port

This block is the host-facing side of a time-of-day counter. A host drives a chip enable, a direction select, a shift clock and one data line. The block moves a 52-bit time/calendar frame across that line, one bit per shift-clock rising edge, least significant bit first. All inputs are already synchronized to the system clock `clk`. The block finds their edges itself. The pad driver is outside: the block supplies the data bit and an output enable.

On a read, the block captures the counter image at the first shift edge and sends it out. The low-supply flag and the test bit are placed into that image. The host may end a read early by dropping the enable. On a write, the block first tells the counters to stop advancing seconds and pulses a divider reset. It then collects the bits, and it hands the frame to the counters only if exactly 52 bits arrived before the enable fell. That hand-over happens one cycle after the enable rises again. The block also keeps a sticky low-supply flag, which is set by a detector pulse and cleared as a side effect of a long read, and a test bit.

Top module: `rtc_serial_port`

## Requirements
- R1: While `ce_i` is low, `sclk_i`, `wr_i` and `sdata_i` have no effect: no bit is counted, `hold_o` is not set and no frame is committed. `sdata_oe_o` is low in the cycle after `ce_i` is sampled low.
- R2: `sdata_oe_o` equals `ce_i & ~wr_i` as sampled one clock earlier. The direction of a session is fixed by `wr_i` at its first shift edge (1 = write, 0 = read).
- R3: On the first shift rising edge of a read, the block captures the frame from `time_i`. Frame bit k then appears on `sdata_o` one clock after the k-th rising edge (k counted from 0). Field layout: seconds [7:0], minutes [15:8], hours [23:16], week [27:24], day [35:28], month [43:36], year [51:44]. Changes to `time_i` after the capture do not affect the read.
- R4: In the read image, bit 7 carries the low-supply flag, bit 41 carries the test bit, and bits 43:42 read as 0.
- R5: Shift edges after the 52nd in a session do nothing. `sdata_o` keeps the last bit, and extra write bits do not alter the committed frame.
- R6: In a write, `div_rst_o` is high while exactly one bit has been received. `hold_o` goes high at the first shift falling edge and stays high until `ce_i` rises again; it is low one clock after that rise.
- R7: A write of at least 52 bits, ended by `ce_i` falling, produces a one-cycle `load_o` pulse. The pulse comes one clock after the next `ce_i` rising edge is sampled. `load_data_o` carries the first 52 bits with bits 7, 41, 43 and 42 cleared. Bit 7 and bit 41 of the written frame become the new flag and test bit.
- R8: A write that ends with fewer than 52 bits commits nothing and leaves the flag and test bit unchanged.
- R9: A `lvd_i` pulse sets `flag_o` on the next clock. A read of 48 or more bits clears the flag when `ce_i` falls. A read of 47 bits or fewer leaves it set.
- R10: When `lvd_i` falls in the same cycle as a flag clear or a commit, the flag ends up set.
- R11: `tm_o` is cleared in the cycle after `ce_i` falls.
- R12: After reset, `sdata_oe_o`, `hold_o`, `div_rst_o`, `load_o`, `flag_o` and `tm_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Access enable (synchronized) |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| sclk_i | input | 1 | Shift clock level (synchronized) |
| sdata_i | input | 1 | Serial data from host |
| sdata_o | output | 1 | Serial data to host |
| sdata_oe_o | output | 1 | Drive enable for the data pad |
| lvd_i | input | 1 | Low-supply detector pulse |
| time_i | input | 52 | Current counter frame |
| load_o | output | 1 | One-cycle commit strobe to the counters |
| load_data_o | output | 52 | Frame to load into the counters |
| hold_o | output | 1 | Stop seconds advance |
| div_rst_o | output | 1 | Reset of the sub-second divider |
| flag_o | output | 1 | Sticky low-supply flag |
| tm_o | output | 1 | Test bit |

## Verification
Two updates to the flag can fall in the same clock. One is the detector pulse. The other is either the clear at the end of a long read or the commit of a written flag bit. The bench lines the detector pulse up with the enable fall that ends a 50-bit read. It also lines the pulse up with the enable rise that commits a frame whose bit 7 is 0. In both cases it expects `flag_o` set on the following clock. The same-cycle pairing of a commit with the first shift edge of a read is also driven. In that case the read must carry the old test bit.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;
    localparam int FRAME_W   = 52;
    localparam int FLAG_BIT  = 7;
    localparam int TM_BIT    = 41;
    localparam int SPARE_LSB = 42;
    localparam int SPARE_MSB = 43;
    localparam int CLR_MIN   = 48;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] ldata;
        logic [CNT_W-1:0]   cnt;
        logic               wr_mode;
        logic               dout;
        logic               oe;
        logic               hold;
        logic               pend;
        logic               load;
        logic               flag;
        logic               tm;
    } port_state_t;
endpackage

// File: rtl/rtc_serial_edge.sv
module rtc_serial_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_o[i] = sig_i[i] & ~prev_q[i];
        assign fall_o[i] = ~sig_i[i] & prev_q[i];
    end
endmodule

// File: rtl/rtc_serial_frame.sv
module rtc_serial_frame
    import rtc_serial_pkg::*;
(
    input  logic [FRAME_W-1:0] cnt_frame_i,
    input  logic               flag_i,
    input  logic               tm_i,
    input  logic [FRAME_W-1:0] shift_i,
    output logic [FRAME_W-1:0] rd_img_o,
    output logic [FRAME_W-1:0] ld_img_o
);
    logic [FRAME_W-1:0] keep;

    // bits owned by this port, not by the counters
    for (genvar i = 0; i < FRAME_W; i++) begin : g_keep
        assign keep[i] = !((i == FLAG_BIT) || (i == TM_BIT) ||
                           ((i >= SPARE_LSB) && (i <= SPARE_MSB)));
    end

    always_comb begin
        rd_img_o                      = cnt_frame_i;
        rd_img_o[SPARE_MSB:SPARE_LSB] = '0;
        rd_img_o[FLAG_BIT]            = flag_i;
        rd_img_o[TM_BIT]              = tm_i;
    end

    assign ld_img_o = shift_i & keep;
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
    import rtc_serial_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_i,
    input  logic               wr_i,
    input  logic               sclk_i,
    input  logic               sdata_i,
    output logic               sdata_o,
    output logic               sdata_oe_o,
    input  logic               lvd_i,
    input  logic [FRAME_W-1:0] time_i,
    output logic               load_o,
    output logic [FRAME_W-1:0] load_data_o,
    output logic               hold_o,
    output logic               div_rst_o,
    output logic               flag_o,
    output logic               tm_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_CLR  = CNT_W'(CLR_MIN);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    port_state_t d, q;
    logic [1:0] rise, fall;
    logic [FRAME_W-1:0] rd_img, ld_img;
    logic ce_rise, ce_fall, s_rise, s_fall;

    rtc_serial_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({sclk_i, ce_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    rtc_serial_frame u_frame (
        .cnt_frame_i (time_i),
        .flag_i      (q.flag),
        .tm_i        (q.tm),
        .shift_i     (q.shreg),
        .rd_img_o    (rd_img),
        .ld_img_o    (ld_img)
    );

    assign ce_rise = rise[0];
    assign ce_fall = fall[0];
    assign s_rise  = rise[1] & ce_i;
    assign s_fall  = fall[1] & ce_i;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        d.oe   = ce_i & ~wr_i;

        if (ce_fall) begin
            d.cnt = '0;
            d.tm  = 1'b0;
            if (q.wr_mode && (q.cnt == CNT_FULL)) d.pend = 1'b1;
            if (!q.wr_mode && (q.cnt >= CNT_CLR)) d.flag = 1'b0;
        end

        if (ce_rise) begin
            d.hold = 1'b0;
            if (q.pend) begin
                d.load  = 1'b1;
                d.ldata = ld_img;
                d.flag  = q.shreg[FLAG_BIT];
                d.tm    = q.shreg[TM_BIT];
                d.pend  = 1'b0;
            end
        end

        if (s_rise) begin
            if (q.cnt == '0) begin
                d.wr_mode = wr_i;
                d.cnt     = CNT_ONE;
                if (wr_i) begin
                    d.shreg = {sdata_i, q.shreg[FRAME_W-1:1]};
                end else begin
                    d.dout  = rd_img[0];
                    d.shreg = {1'b0, rd_img[FRAME_W-1:1]};
                end
            end else if (q.cnt < CNT_FULL) begin
                d.cnt = q.cnt + CNT_ONE;
                if (q.wr_mode) begin
                    d.shreg = {sdata_i, q.shreg[FRAME_W-1:1]};
                end else begin
                    d.dout  = q.shreg[0];
                    d.shreg = {1'b0, q.shreg[FRAME_W-1:1]};
                end
            end
        end

        if (s_fall && q.wr_mode && (q.cnt != '0)) d.hold = 1'b1;

        if (lvd_i) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdata_o     = q.dout;
    assign sdata_oe_o  = q.oe;
    assign load_o      = q.load;
    assign load_data_o = q.ldata;
    assign hold_o      = q.hold;
    assign div_rst_o   = q.wr_mode & (q.cnt == CNT_ONE);
    assign flag_o      = q.flag;
    assign tm_o        = q.tm;
endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_i,
    input logic lvd_i,
    input logic sdata_oe_o,
    input logic load_o,
    input logic hold_o,
    input logic flag_o,
    input logic tm_o
);
    AST_OE_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> !sdata_oe_o);                                   // R1
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);                                      // R7
    AST_LOAD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ($past(ce_i) && !$past(ce_i, 2)));             // R7
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_i) |=> !hold_o);                                 // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_i |=> flag_o);                                        // R10
    AST_TM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_i) |=> !tm_o);                                   // R11
endmodule

bind rtc_serial_port rtc_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (ce_i),
    .lvd_i      (lvd_i),
    .sdata_oe_o (sdata_oe_o),
    .load_o     (load_o),
    .hold_o     (hold_o),
    .flag_o     (flag_o),
    .tm_o       (tm_o)
);

// File: tb/rtc_serial_port_bench.sv
module rtc_serial_port_bench;
    localparam int FW = 52;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce = 1'b0, wr = 1'b0, sclk = 1'b0, sdi = 1'b0, lvd = 1'b0;
    logic [FW-1:0] tin = '0;
    logic sdo, oe, load, hold, divr, flag, tm;
    logic [FW-1:0] ldata;

    int vectors = 0, errors = 0, cycles = 0;

    always #10 clk = ~clk;

    rtc_serial_port u_rtc_serial_port (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .wr_i(wr), .sclk_i(sclk),
        .sdata_i(sdi), .sdata_o(sdo), .sdata_oe_o(oe), .lvd_i(lvd),
        .time_i(tin), .load_o(load), .load_data_o(ldata), .hold_o(hold),
        .div_rst_o(divr), .flag_o(flag), .tm_o(tm)
    );

    // behavioural reference
    bit m_pce, m_psc, m_wr, m_dout, m_oe, m_hold, m_pend, m_load, m_flag, m_tm;
    int m_n;
    bit m_rimg[FW];
    bit m_wq[$];
    bit m_pimg[FW];
    logic [FW-1:0] m_ld;

    function automatic logic [FW-1:0] img(logic [FW-1:0] v, bit f, bit t);
        logic [FW-1:0] r = v;
        r[7] = f; r[41] = t; r[43:42] = 2'b00;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pce = 0; m_psc = 0; m_wr = 0; m_dout = 0; m_oe = 0; m_hold = 0;
            m_pend = 0; m_load = 0; m_flag = 0; m_tm = 0; m_n = 0; m_ld = '0;
        end else begin
            bit f_ce, r_ce, r_sc, f_sc;
            bit nf, nt;
            f_ce = m_pce && !ce;  r_ce = !m_pce && ce;
            r_sc = ce && sclk && !m_psc;  f_sc = ce && !sclk && m_psc;
            nf = m_flag; nt = m_tm;
            m_load = 0;
            m_oe = ce && !wr;
            if (f_ce) begin
                if (m_wr && m_n == FW) begin
                    m_pend = 1;
                    foreach (m_pimg[i]) m_pimg[i] = m_wq[i];
                end
                if (!m_wr && m_n >= 48) nf = 0;
                nt = 0;
                m_n = 0;
            end
            if (r_sc) begin
                if (m_n == 0) begin
                    logic [FW-1:0] t;
                    m_wr = wr;
                    m_wq.delete();
                    if (wr) m_wq.push_back(sdi);
                    else begin
                        t = img(tin, m_flag, m_tm);
                        foreach (m_rimg[i]) m_rimg[i] = t[i];
                        m_dout = m_rimg[0];
                    end
                    m_n = 1;
                end else if (m_n < FW) begin
                    if (m_wr) m_wq.push_back(sdi);
                    else m_dout = m_rimg[m_n];
                    m_n++;
                end
            end
            if (r_ce) begin
                m_hold = 0;
                if (m_pend) begin
                    m_load = 1; m_pend = 0;
                    foreach (m_pimg[i]) m_ld[i] = m_pimg[i];
                    nf = m_ld[7]; nt = m_ld[41];
                    m_ld[7] = 0; m_ld[41] = 0; m_ld[43:42] = 2'b00;
                end
            end
            if (f_sc && m_wr && m_n != 0) m_hold = 1;
            if (lvd) nf = 1;
            m_flag = nf; m_tm = nt;
            m_pce = ce; m_psc = sclk;
        end
    end

    task automatic chk(bit ok, string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk(oe == m_oe, "R2 oe", oe, m_oe);
            chk(sdo == m_dout, "R3 sdata", sdo, m_dout);
            chk(hold == m_hold, "R6 hold", hold, m_hold);
            chk(divr == (m_wr && m_n == 1), "R6 div_rst", divr, m_wr && m_n == 1);
            chk(load == m_load, "R7 load", load, m_load);
            if (m_load) chk(ldata == m_ld, "R7 load_data", ldata, m_ld);
            chk(flag == m_flag, "R9 flag", flag, m_flag);
            chk(tm == m_tm, "R11 tm", tm, m_tm);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit d, output bit got);
        @(negedge clk); sdi = d; sclk = 1;
        @(negedge clk); got = sdo; sclk = 0;
        @(negedge clk);
    endtask

    task automatic do_write(logic [FW-1:0] fr, int nb, bit drop = 1);
        bit g;
        @(negedge clk); wr = 1; ce = 1; tick(2);
        for (int i = 0; i < nb; i++) pulse((i < FW) ? fr[i] : ~fr[i % FW], g);
        if (drop) begin @(negedge clk); ce = 0; tick(2); end
    endtask

    task automatic do_read(int nb, output logic [FW-1:0] got, input bit drop = 1);
        bit g;
        got = '0;
        @(negedge clk); wr = 0; ce = 1; tick(2);
        for (int i = 0; i < nb; i++) begin
            pulse(1'b0, g);
            if (i < FW) got[i] = g;
            if (i == 1) tin = ~tin;
        end
        if (drop) begin @(negedge clk); ce = 0; tick(2); end
    endtask

    task automatic ce_up_down();
        @(negedge clk); ce = 1; tick(3); ce = 0; tick(2);
    endtask

    initial begin : watchdog
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        logic [FW-1:0] got, fa, fb, exp_img;
        bit g;
        fa = 52'hA_5C3E_1F27_7934;  fa[7] = 0; fa[41] = 1;
        fb = 52'h9_1842_3706_1259;
        tick(3); rst_n = 1; tick(1);

        // R12 reset state
        chk(!oe && !hold && !divr && !load && !flag && !tm, "R12 reset", {oe,hold,divr,load,flag,tm}, '0);

        // R1 clocks with CE low are ignored
        wr = 1;
        for (int i = 0; i < 10; i++) pulse(1'b1, g);
        chk(!hold && !oe, "R1 idle clocks", {hold, oe}, '0);
        ce_up_down();
        chk(!load && !hold, "R1 no commit", {load, hold}, '0);

        // write with extra bits, check freeze and divider reset
        @(negedge clk); wr = 1; ce = 1; tick(2);
        chk(!oe, "R2 no drive in write", oe, 0);
        pulse(fa[0], g);
        chk(divr, "R6 div_rst after first bit", divr, 1);
        chk(hold, "R6 hold after first fall", hold, 1);
        pulse(fa[1], g);
        chk(!divr, "R6 div_rst released", divr, 0);
        for (int i = 2; i < FW + 3; i++) pulse((i < FW) ? fa[i] : ~fa[i % FW], g); // R5 extras
        @(negedge clk); ce = 0; tick(2);
        chk(hold, "R6 hold kept while CE low", hold, 1);
        @(negedge clk); ce = 1;
        @(negedge clk);
        chk(load && ldata == img(fa, 0, 0), "R7 commit data", ldata, img(fa, 0, 0));
        chk(!hold, "R6 hold released", hold, 0);
        chk(tm, "R7 test bit written", tm, 1);

        // R3/R4 full read in the same session, time_i changes mid read
        tin = fb;
        exp_img = img(fb, 0, 1);
        @(negedge clk); wr = 0; tick(2);
        chk(oe, "R2 drive in read", oe, 1);
        for (int i = 0; i < FW + 2; i++) begin
            pulse(1'b0, g);
            if (i < FW) got[i] = g;
            if (i == 3) tin = ~fb;
            if (i >= FW) chk(g == exp_img[FW-1], "R5 dout holds", g, exp_img[FW-1]);
        end
        chk(got == exp_img, "R3 R4 read frame", got, exp_img);
        @(negedge clk); ce = 0; tick(2);
        chk(!tm, "R11 tm cleared", tm, 0);
        chk(!oe, "R1 oe off", oe, 0);

        // R9 flag set, short read keeps it, long read clears it
        @(negedge clk); lvd = 1; @(negedge clk); lvd = 0; tick(1);
        chk(flag, "R9 flag set", flag, 1);
        do_read(47, got);
        chk(got[7], "R4 flag in image", got[7], 1);
        chk(flag, "R9 47-bit read keeps flag", flag, 1);
        do_read(48, got);
        chk(!flag, "R9 48-bit read clears flag", flag, 0);

        // R8 partial write discarded
        @(negedge clk); lvd = 1; @(negedge clk); lvd = 0;
        do_write(fb, 30);
        chk(hold, "R6 hold after partial write", hold, 1);
        @(negedge clk); ce = 1; tick(2);
        chk(!load && flag && !tm, "R8 partial write discarded", {load, flag, tm}, 3'b010);
        @(negedge clk); ce = 0; tick(2);

        // R10 detector pulse coincides with read clear
        do_read(50, got, 0);
        @(negedge clk); ce = 0; lvd = 1; @(negedge clk); lvd = 0; tick(1);
        chk(flag, "R10 set beats clear", flag, 1);

        // R10 detector pulse coincides with commit of flag=0
        fa[7] = 0;
        do_write(fa, FW);
        @(negedge clk); ce = 1; lvd = 1; @(negedge clk); lvd = 0; wr = 0; ce = 0; tick(2);
        chk(flag, "R10 set beats commit", flag, 1);

        // commit and first read edge in the same cycle: old test bit seen
        fa[41] = 1;
        do_write(fa, FW);
        @(negedge clk); wr = 0; ce = 1; sclk = 1; tin = fb;
        @(negedge clk); g = sdo; sclk = 0;
        chk(tm, "R7 commit alongside read", tm, 1);
        tick(2);
        for (int i = 1; i < 42; i++) begin pulse(1'b0, g); got[i] = g; end
        chk(!got[41], "R4 read keeps pre-commit test bit", got[41], 0);
        @(negedge clk); ce = 0; tick(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule